// File: doc/BRIEF.md
# Threaded-Code Next-Step Sequencer

This block carries out the inner "advance and dispatch" step of a direct-threaded interpreter as one instruction with a fixed cycle count. The interpretive pointer is not kept in a register. It sits in two adjacent zero-page bytes, and the operand byte of the instruction names the first of them. When started, the sequencer reads the 16-bit pointer and then the 16-bit code address that the pointer refers to. It writes the pointer back to zero page moved forward by one word, and it hands the fetched code address out as the new program counter.

The surrounding core fetches the opcode and decodes it. In the opcode cycle it raises `start` and presents the operand byte. The sequencer then drives a byte-wide memory bus that has an asynchronous read path. The operand cycle, four reads and two writes follow in a fixed order. The new program counter appears together with a one-cycle `done` pulse. The only temporary storage is two 16-bit holding registers, one for addresses and one for data, which stand in for the address generator and ALU latches the core already has.

Top module: `tnx_next_seq`

## Requirements
- R1: While and right after reset, `busy`, `done`, `mem_re` and `mem_we` are 0 and `pc_value` is 0x0000.
- R2: A `start` that is sampled while idle launches one operation. `done` is high for exactly one cycle, which is the 8th clock after the start edge. `busy` is high from the first cycle after the start edge through the `done` cycle.
- R3: The pointer is read as its low byte at address {0x00, op} and then its high byte at {0x00, (op+1) mod 256}, so an operand of 0xFF takes the high byte from 0x0000.
- R4: The target is read as its low byte at the pointer value P and then its high byte at (P+1) mod 65536.
- R5: After the reads, the low byte of P+2 is written to {0x00, op} and then the high byte to {0x00, (op+1) mod 256}. The carry from the low byte goes into the high byte.
- R6: In the `done` cycle, `pc_value` equals the fetched target, high byte times 256 plus low byte. It keeps that value until the next `done`.
- R7: A `start` that arrives while an operation is in progress, including the `done` cycle, is ignored. The operand in use does not change, and no extra bus cycles follow.
- R8: The bus order per operation is: one idle operand cycle, four reads, two writes. `mem_re` and `mem_we` are never high together, and the bus is idle at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled in the opcode cycle |
| zp_op | input | 8 | Zero-page operand naming the pointer's low byte |
| mem_addr | output | 16 | Bus address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| pc_value | output | 16 | Program counter loaded from the target |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The hard cases sit at the address seams. One is an operand of 0xFF, where the pointer's high byte must come from 0x0000. Another is a pointer of 0xFFFF, where the target straddles the top of memory and the advanced pointer becomes 0x0001. A third is a pointer low byte of 0xFE or 0xFF, where the carry has to enter the high byte. The stimulus places memory contents so that each of these seams is crossed directly. It also runs chained steps on one operand, so that each step consumes the pointer that the previous step wrote back. Further stimulus raises `start` in the middle of a run and in the `done` cycle, and the scoreboard checks that no stray bus cycles follow.

// File: rtl/tnx_pkg.sv
package tnx_pkg;
  localparam int unsigned TNX_DW = 8;
  localparam int unsigned TNX_AW = 2 * TNX_DW;
  localparam int unsigned TNX_STEP = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPND, ST_PTR_LO, ST_PTR_HI, ST_TGT_LO, ST_TGT_HI,
    ST_WR_LO, ST_WR_HI, ST_FIN
  } tnx_state_e;

  typedef struct packed {
    logic rd_ptr_lo;
    logic rd_ptr_hi;
    logic rd_tgt_lo;
    logic rd_tgt_hi;
    logic wr_lo;
    logic wr_hi;
  } tnx_strobe_t;

  // Second byte of a zero-page pair; wraps inside the page.
  function automatic logic [TNX_DW-1:0] zp_succ(input logic [TNX_DW-1:0] a);
    return a + 1'b1;
  endfunction

  // Next byte address in the full space; wraps at the top.
  function automatic logic [TNX_AW-1:0] word_succ(input logic [TNX_AW-1:0] w);
    return w + 1'b1;
  endfunction

  // Pointer advanced past one code word.
  function automatic logic [TNX_AW-1:0] ptr_bump(input logic [TNX_AW-1:0] w,
                                                 input int unsigned step);
    return w + TNX_AW'(step);
  endfunction
endpackage

// File: rtl/tnx_fsm.sv
module tnx_fsm
  import tnx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        accept,
  output logic        busy,
  output logic        fin,
  output tnx_strobe_t stb
);
  tnx_state_e st, nxt;

  assign accept = (st == ST_IDLE) && start;
  assign busy   = (st != ST_IDLE);
  assign fin    = (st == ST_FIN);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:   nxt = start ? ST_OPND : ST_IDLE;
      ST_OPND:   nxt = ST_PTR_LO;
      ST_PTR_LO: nxt = ST_PTR_HI;
      ST_PTR_HI: nxt = ST_TGT_LO;
      ST_TGT_LO: nxt = ST_TGT_HI;
      ST_TGT_HI: nxt = ST_WR_LO;
      ST_WR_LO:  nxt = ST_WR_HI;
      ST_WR_HI:  nxt = ST_FIN;
      ST_FIN:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    stb           = '0;
    stb.rd_ptr_lo = (st == ST_PTR_LO);
    stb.rd_ptr_hi = (st == ST_PTR_HI);
    stb.rd_tgt_lo = (st == ST_TGT_LO);
    stb.rd_tgt_hi = (st == ST_TGT_HI);
    stb.wr_lo     = (st == ST_WR_LO);
    stb.wr_hi     = (st == ST_WR_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  // At most one bus phase per cycle.
  a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

// File: rtl/tnx_hold_regs.sv
module tnx_hold_regs
  import tnx_pkg::*;
#(
  parameter int unsigned LANES = TNX_AW / TNX_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tnx_strobe_t       stb,
  input  logic [TNX_DW-1:0] rdata,
  output logic [TNX_AW-1:0] ptr_q,
  output logic [TNX_AW-1:0] tgt_q
);
  logic [LANES-1:0] ptr_cap, tgt_cap;
  assign ptr_cap = {stb.rd_ptr_hi, stb.rd_ptr_lo};
  assign tgt_cap = {stb.rd_tgt_hi, stb.rd_tgt_lo};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[i*TNX_DW +: TNX_DW] <= '0;
        tgt_q[i*TNX_DW +: TNX_DW] <= '0;
      end else begin
        if (ptr_cap[i]) ptr_q[i*TNX_DW +: TNX_DW] <= rdata;
        if (tgt_cap[i]) tgt_q[i*TNX_DW +: TNX_DW] <= rdata;
      end
    end
  end
endmodule

// File: rtl/tnx_addr_gen.sv
module tnx_addr_gen
  import tnx_pkg::*;
#(
  parameter int unsigned STEP = TNX_STEP
) (
  input  tnx_strobe_t       stb,
  input  logic [TNX_DW-1:0] zp,
  input  logic [TNX_AW-1:0] ptr_q,
  output logic [TNX_AW-1:0] addr,
  output logic [TNX_DW-1:0] wdata,
  output logic              re,
  output logic              we
);
  localparam logic [TNX_DW-1:0] ZP_PAGE = '0;

  logic [TNX_AW-1:0] zp_lo_a, zp_hi_a, bumped;
  assign zp_lo_a = {ZP_PAGE, zp};
  assign zp_hi_a = {ZP_PAGE, zp_succ(zp)};
  assign bumped  = ptr_bump(ptr_q, STEP);

  assign re = stb.rd_ptr_lo | stb.rd_ptr_hi | stb.rd_tgt_lo | stb.rd_tgt_hi;
  assign we = stb.wr_lo | stb.wr_hi;

  always_comb begin
    addr  = '0;
    wdata = '0;
    if (stb.rd_ptr_lo) addr = zp_lo_a;
    if (stb.rd_ptr_hi) addr = zp_hi_a;
    if (stb.rd_tgt_lo) addr = ptr_q;
    if (stb.rd_tgt_hi) addr = word_succ(ptr_q);
    if (stb.wr_lo) begin
      addr  = zp_lo_a;
      wdata = bumped[TNX_DW-1:0];
    end
    if (stb.wr_hi) begin
      addr  = zp_hi_a;
      wdata = bumped[TNX_AW-1:TNX_DW];
    end
  end
endmodule

// File: rtl/tnx_next_seq.sv
module tnx_next_seq
  import tnx_pkg::*;
#(
  parameter int unsigned STEP = TNX_STEP
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  zp_op,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_re,
  output logic        mem_we,
  output logic [15:0] pc_value,
  output logic        done,
  output logic        busy
);
  tnx_strobe_t       stb;
  logic              accept;
  logic [TNX_DW-1:0] zp_q;
  logic [TNX_AW-1:0] ptr_q, tgt_q;

  tnx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .busy(busy), .fin(done), .stb(stb)
  );

  tnx_hold_regs u_hold (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rdata(mem_rdata),
    .ptr_q(ptr_q), .tgt_q(tgt_q)
  );

  tnx_addr_gen #(.STEP(STEP)) u_agen (
    .stb(stb), .zp(zp_q), .ptr_q(ptr_q),
    .addr(mem_addr), .wdata(mem_wdata), .re(mem_re), .we(mem_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zp_q     <= '0;
      pc_value <= '0;
    end else begin
      if (accept)     zp_q     <= zp_op;
      if (stb.wr_hi)  pc_value <= tgt_q;
    end
  end

  a_r8_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_ptr_hi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rd_ptr_hi |-> (mem_addr[15:8] == 8'h00) &&
                      (mem_addr[7:0] == 8'($past(mem_addr[7:0]) + 8'd1)));
  a_r4_tgt_hi_next: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rd_tgt_hi |-> mem_addr == 16'($past(mem_addr) + 16'd1));
  a_r5_wr_hi_addr: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wr_hi |-> (mem_addr[15:8] == 8'h00) &&
                  (mem_addr[7:0] == 8'($past(mem_addr[7:0]) + 8'd1)));
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc_value));
  a_r7_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(zp_q));
endmodule

// File: tb/sim_tnx_next_seq.sv
module sim_tnx_next_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  zp_op = 8'h00;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;
  logic        mem_re, mem_we;
  logic [15:0] pc_value;
  logic        done, busy;

  int compared = 0;
  int mismatched = 0;

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic [7:0]  data;
  } bus_item_t;
  bus_item_t exp_q[$];

  logic [7:0] mem [logic [15:0]];

  always #10 clk = ~clk;

  tnx_next_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .zp_op(zp_op),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_we(mem_we), .pc_value(pc_value),
    .done(done), .busy(busy)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Memory model and bus monitor, both mid-cycle.
  always @(negedge clk) begin
    if (rst_n && (mem_re || mem_we)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected bus cycle", {mem_we, mem_re, 14'h0, mem_addr}, 32'h0);
      end else begin
        bus_item_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.addr, "R8", "bus address", mem_addr, e.addr);
        check(mem_we == e.wr && mem_re == !e.wr, "R8", "bus direction",
              {mem_we, mem_re}, {e.wr, !e.wr});
        if (e.wr) check(mem_wdata == e.data, "R5", "write data", mem_wdata, e.data);
      end
    end
    if (mem_we) mem[mem_addr] = mem_wdata;
    mem_rdata = rd(mem_addr);
  end

  // One next-step; intr: 0 none, 1 start mid-run, 2 start in done cycle.
  task automatic run_next(input logic [7:0] zp, input int intr, input string tag);
    logic [15:0] p, t, np;
    logic [7:0]  zh;
    zh = zp + 8'd1;
    p  = {rd({8'h00, zh}), rd({8'h00, zp})};
    t  = {rd(p + 16'd1), rd(p)};
    np = p + 16'd2;
    exp_q.push_back('{{8'h00, zp}, 1'b0, 8'h00});   // R3
    exp_q.push_back('{{8'h00, zh}, 1'b0, 8'h00});   // R3
    exp_q.push_back('{p, 1'b0, 8'h00});             // R4
    exp_q.push_back('{p + 16'd1, 1'b0, 8'h00});     // R4
    exp_q.push_back('{{8'h00, zp}, 1'b1, np[7:0]}); // R5
    exp_q.push_back('{{8'h00, zh}, 1'b1, np[15:8]});// R5
    start = 1'b1;
    zp_op = zp;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    for (int k = 2; k <= 8; k++) begin
      if (intr == 1 && k == 3) begin start = 1'b1; zp_op = zp ^ 8'h5A; end
      if (intr == 1 && k == 5) start = 1'b0;
      @(negedge clk);
      if (k == 7) check(done == 1'b0, "R2", {tag, " early done"}, done, 0);
    end
    check(done == 1'b1, "R2", {tag, " done on 8th clock"}, done, 1);
    check(pc_value == t, "R6", {tag, " pc value"}, pc_value, t);
    if (intr == 2) begin start = 1'b1; zp_op = zp ^ 8'hA5; end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && busy == 1'b0, "R2", {tag, " idle after done"}, {done, busy}, 0);
    check(pc_value == t, "R6", {tag, " pc held"}, pc_value, t);
    check(exp_q.size() == 0, "R8", {tag, " all bus cycles seen"}, exp_q.size(), 0);
    if (intr != 0) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        check(busy == 1'b0 && !mem_re && !mem_we, "R7", {tag, " stray start ignored"},
              {busy, mem_re, mem_we}, 0);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we && pc_value == 16'h0, "R1", "reset state",
          {busy, done, mem_re, mem_we, pc_value}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R1", "after reset",
          {busy, done, mem_re, mem_we}, 0);

    // plain step
    mem[16'h0040] = 8'h34; mem[16'h0041] = 8'h12;
    mem[16'h1234] = 8'hCD; mem[16'h1235] = 8'hAB;
    run_next(8'h40, 0, "plain");
    check(rd(16'h0040) == 8'h36 && rd(16'h0041) == 8'h12, "R5", "pointer +2",
          {rd(16'h0041), rd(16'h0040)}, 16'h1236);

    // carry into high byte (R5)
    mem[16'h0010] = 8'hFE; mem[16'h0011] = 8'h12;
    mem[16'h12FE] = 8'h11; mem[16'h12FF] = 8'h22;
    run_next(8'h10, 0, "carry");
    check({rd(16'h0011), rd(16'h0010)} == 16'h1300, "R5", "carry pointer",
          {rd(16'h0011), rd(16'h0010)}, 16'h1300);

    // operand 0xFF: high byte from 0x0000 (R3)
    mem[16'h00FF] = 8'h56; mem[16'h0000] = 8'h34;
    mem[16'h3456] = 8'h78; mem[16'h3457] = 8'h9A;
    run_next(8'hFF, 0, "zpwrap");
    check({rd(16'h0000), rd(16'h00FF)} == 16'h3458, "R3", "wrapped pointer",
          {rd(16'h0000), rd(16'h00FF)}, 16'h3458);

    // pointer 0xFFFF: target straddles top of memory (R4)
    mem[16'h0080] = 8'hFF; mem[16'h0081] = 8'hFF;
    mem[16'hFFFF] = 8'hEF; mem[16'h0000] = 8'hBE;
    run_next(8'h80, 0, "topwrap");
    check({rd(16'h0081), rd(16'h0080)} == 16'h0001, "R4", "pointer past top",
          {rd(16'h0081), rd(16'h0080)}, 16'h0001);

    // chained thread walk on one operand
    mem[16'h0020] = 8'h00; mem[16'h0021] = 8'h50;
    for (int i = 0; i < 6; i++) mem[16'h5000 + 16'(i)] = 8'(8'h60 + i * 8'h13);
    for (int i = 0; i < 3; i++) run_next(8'h20, 0, "chain");
    check({rd(16'h0021), rd(16'h0020)} == 16'h5006, "R5", "chain end pointer",
          {rd(16'h0021), rd(16'h0020)}, 16'h5006);

    // start during a run and during done are ignored (R7)
    mem[16'h0030] = 8'h00; mem[16'h0031] = 8'h70;
    mem[16'h7000] = 8'h01; mem[16'h7001] = 8'h02;
    mem[16'h7002] = 8'h03; mem[16'h7003] = 8'h04;
    run_next(8'h30, 1, "midstart");
    run_next(8'h30, 2, "donestart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule